// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-bit bidirectional general-purpose I/O port for a small microcontroller core. Each bit has an output data latch and a direction latch. When the direction bit is 0 the pad driver is enabled from the data latch. When it is 1 the pin is an input, and its weak pull-up may be switched on. The CPU loads the latches from a shared write bus under separate strobes. It reads either the synchronized pin levels or the direction latch back on a combinational read bus.

Each port read also stores the upper four pin levels in a reference latch. From then on, any input pin among bits 7 to 4 that differs from its stored level raises one shared sticky change flag. Bit 0 doubles as an external interrupt input, with its own sticky flag and a selectable active edge. Both flags stay set until software clears them with a dedicated strobe. A third configuration strobe sets the global pull-up disable bit and the edge select.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset every direction bit is 1 (all pin output enables 0), the data latch is 0, pull-ups are disabled (pull-up disable bit = 1), the edge select is rising, and both flags are 0.
- R2: A `data_wr` pulse loads `bus_wdata` into the data latch driven on `pin_out`. A `dir_wr` pulse loads the direction latch, so `pin_oe` becomes its inverse. While `dir_rd` is high and `port_rd` is low, `rdata` returns the direction latch.
- R3: A `cfg_wr` pulse loads bit 7 of `bus_wdata` as the pull-up disable bit and bit 6 as the edge select (1 = rising, 0 = falling). `pin_pu[i]` is 1 exactly when the disable bit is 0 and direction bit i is 1.
- R4: While `port_rd` is high, `rdata` returns the pin levels after a two-flop synchronizer (two cycles of latency), never the data latch. With no read strobe, `rdata` is 0.
- R5: A synchronized level on an input pin among bits 7 to 4 that differs from its reference bit sets `chg_flag` on the next clock edge. Changes on bits 3 to 0 never set it.
- R6: A pin among bits 7 to 4 whose direction bit is 0 never causes a change mismatch.
- R7: The edge that ends a `port_rd` pulse stores the synchronized bits 7 to 4 as the new reference. `chg_flag` stays set until `chg_clr`. If a mismatch is present in the clear cycle, the flag stays set.
- R8: `ext_flag` sets on the selected edge of the synchronized bit 0 and stays set until an `ext_clr` pulse. The other edge leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wdata | input | 8 | CPU write data |
| data_wr | input | 1 | Load the data latch |
| dir_wr | input | 1 | Load the direction latch |
| cfg_wr | input | 1 | Load pull-up disable (bit 7) and edge select (bit 6) |
| port_rd | input | 1 | Read the synchronized pins and capture the change reference |
| dir_rd | input | 1 | Read the direction latch |
| chg_clr | input | 1 | Clear the change flag |
| ext_clr | input | 1 | Clear the external interrupt flag |
| rdata | output | 8 | CPU read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Weak pull-up enables |
| chg_flag | output | 1 | Sticky change-interrupt flag |
| ext_flag | output | 1 | Sticky external interrupt flag |

## Verification
A corrupted direction or data latch shows on `pin_oe`, `pin_out` and `pin_pu` at the first negative edge after the write, and on `rdata` during a direction read. A stale or wrong reference latch is visible only through `chg_flag`. It shows up three edges after a pin change, or as a flag that fails to clear after a read and clear sequence. For this reason the bench places every flag check at that exact cycle. An edge detector holding the wrong previous level shows as `ext_flag` setting on the wrong polarity.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  localparam int CFG_PUDIS_BIT = 7;
  localparam int CFG_EDGE_BIT  = 6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] lvl,
  input  logic [NB-1:0] is_in,
  input  logic          cap_en,
  input  logic          clr,
  output logic          flag
);
  logic [NB-1:0] ref_q, ref_d;
  logic [NB-1:0] mism;
  logic          flag_q, flag_d;

  assign mism = is_in & (lvl ^ ref_q);

  always_comb begin
    ref_d  = cap_en ? lvl : ref_q;
    flag_d = flag_q;
    if (|mism)    flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/gpio_ext_irq.sv
module gpio_ext_irq
  import gpio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  edge_sel_e sel,
  input  logic      clr,
  output logic      flag
);
  logic prev_q;
  logic flag_q, flag_d;
  logic hit;

  assign hit = (sel == EDGE_RISE) ? (lvl & ~prev_q) : (~lvl & prev_q);

  always_comb begin
    flag_d = flag_q;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_pkg::*;
#(
  parameter int W       = 8,
  parameter int CHG_LO  = 4,
  parameter int SYNC_N  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_wdata,
  input  logic         data_wr,
  input  logic         dir_wr,
  input  logic         cfg_wr,
  input  logic         port_rd,
  input  logic         dir_rd,
  input  logic         chg_clr,
  input  logic         ext_clr,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu,
  output logic         chg_flag,
  output logic         ext_flag
);
  localparam int NB = W - CHG_LO;

  logic [W-1:0] data_q, data_d;
  logic [W-1:0] dir_q, dir_d;
  logic         pudis_q, pudis_d;
  edge_sel_e    edge_q, edge_d;
  logic [W-1:0] pin_s;

  always_comb begin
    data_d  = data_wr ? bus_wdata : data_q;
    dir_d   = dir_wr  ? bus_wdata : dir_q;
    pudis_d = pudis_q;
    edge_d  = edge_q;
    if (cfg_wr) begin
      pudis_d = bus_wdata[CFG_PUDIS_BIT];
      edge_d  = edge_sel_e'(bus_wdata[CFG_EDGE_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '1;
      pudis_q <= 1'b1;
      edge_q  <= EDGE_RISE;
    end else begin
      data_q  <= data_d;
      dir_q   <= dir_d;
      pudis_q <= pudis_d;
      edge_q  <= edge_d;
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (pin_s)
  );

  gpio_chg_det #(.NB(NB)) u_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (pin_s[W-1:CHG_LO]),
    .is_in  (dir_q[W-1:CHG_LO]),
    .cap_en (port_rd),
    .clr    (chg_clr),
    .flag   (chg_flag)
  );

  gpio_ext_irq u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_s[0]),
    .sel   (edge_q),
    .clr   (ext_clr),
    .flag  (ext_flag)
  );

  always_comb begin
    if (port_rd)     rdata = pin_s;
    else if (dir_rd) rdata = dir_q;
    else             rdata = '0;
  end

  assign pin_out = data_q;
  assign pin_oe  = ~dir_q;
  assign pin_pu  = dir_q & {W{~pudis_q}};
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_wdata,
  input logic         data_wr,
  input logic         dir_wr,
  input logic         chg_clr,
  input logic         ext_clr,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_pu,
  input logic         chg_flag,
  input logic         ext_flag
);
  assert_out_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (pin_out == $past(bus_wdata)));

  assert_oe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (pin_oe == ~$past(bus_wdata)));

  assert_pu_only_inputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_oe) == '0));

  assert_chg_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !chg_clr) |=> chg_flag);

  assert_ext_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag && !ext_clr) |=> ext_flag);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W)) u_chk (.*);

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_wdata;
  logic       data_wr, dir_wr, cfg_wr, port_rd, dir_rd, chg_clr, ext_clr;
  logic [7:0] rdata, pin_in, pin_out, pin_oe, pin_pu;
  logic       chg_flag, ext_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_chg_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata),
    .data_wr(data_wr), .dir_wr(dir_wr), .cfg_wr(cfg_wr),
    .port_rd(port_rd), .dir_rd(dir_rd), .chg_clr(chg_clr), .ext_clr(ext_clr),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pu(pin_pu), .chg_flag(chg_flag), .ext_flag(ext_flag)
  );

  // {dir, data, cfg, expected pull-ups}
  localparam logic [31:0] VEC [6] = '{
    {8'hFF, 8'h00, 8'h80, 8'h00},
    {8'hFF, 8'h55, 8'h40, 8'hFF},
    {8'h0F, 8'hA5, 8'h40, 8'h0F},
    {8'hF0, 8'h3C, 8'h00, 8'hF0},
    {8'h00, 8'hFF, 8'h40, 8'h00},
    {8'h5A, 8'h81, 8'hC0, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // which: 0 data, 1 dir, 2 cfg, 3 chg_clr, 4 ext_clr, 5 port_rd
  task automatic pulse(input int which, input logic [7:0] v);
    @(negedge clk);
    bus_wdata = v;
    case (which)
      0: data_wr = 1'b1;
      1: dir_wr  = 1'b1;
      2: cfg_wr  = 1'b1;
      3: chg_clr = 1'b1;
      4: ext_clr = 1'b1;
      default: port_rd = 1'b1;
    endcase
    @(negedge clk);
    {data_wr, dir_wr, cfg_wr, chg_clr, ext_clr, port_rd} = '0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic resync_clear;
    wait_n(3);
    pulse(5, 8'h00);
    pulse(3, 8'h00);
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_wdata = '0;
    pin_in = '0;
    {data_wr, dir_wr, cfg_wr, chg_clr, ext_clr, port_rd, dir_rd} = '0;
    wait_n(3);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 pu", pin_pu, 8'h00);
    check("R1 flags", {6'b0, chg_flag, ext_flag}, 8'h00);
    rst_n = 1'b1;
    wait_n(2);

    // table walk (R2, R3)
    foreach (VEC[i]) begin
      pulse(1, VEC[i][31:24]);
      pulse(0, VEC[i][23:16]);
      pulse(2, VEC[i][15:8]);
      check("R2 out", pin_out, VEC[i][23:16]);
      check("R2 oe", pin_oe, ~VEC[i][31:24]);
      check("R3 pu", pin_pu, VEC[i][7:0]);
      dir_rd = 1'b1; #1;
      check("R2 dir readback", rdata, VEC[i][31:24]);
      dir_rd = 1'b0;
    end

    // all inputs, pull-ups on, rising edge
    pulse(1, 8'hFF);
    pulse(2, 8'h40);
    pulse(0, 8'h3C);

    // R4: port read returns synchronized pins, not data latch
    pin_in = 8'hA5;
    wait_n(1);
    port_rd = 1'b1; #1;
    check("R4 latency", rdata, 8'h00);
    port_rd = 1'b0;
    wait_n(1);
    port_rd = 1'b1; #1;
    check("R4 read", rdata, 8'hA5);
    port_rd = 1'b0; #1;
    check("R4 idle", rdata, 8'h00);

    // R5: establish reference 0x00 and clear
    pin_in = 8'h00;
    resync_clear();
    check("R5 clean", {7'b0, chg_flag}, 8'h00);
    pin_in = 8'h07;
    wait_n(4);
    check("R5 low bits ignored", {7'b0, chg_flag}, 8'h00);
    pin_in = 8'h17;
    wait_n(2);
    check("R5 not yet", {7'b0, chg_flag}, 8'h00);
    wait_n(1);
    check("R5 set", {7'b0, chg_flag}, 8'h01);

    // R7: clear with mismatch held keeps flag
    pulse(3, 8'h00);
    check("R7 clear blocked", {7'b0, chg_flag}, 8'h01);
    pulse(5, 8'h00);
    pulse(3, 8'h00);
    check("R7 clear after read", {7'b0, chg_flag}, 8'h00);
    wait_n(3);
    check("R7 stays clear", {7'b0, chg_flag}, 8'h00);

    // R6: output pins never mismatch
    pulse(1, 8'h0F);
    pin_in = 8'hF7;
    wait_n(5);
    check("R6 outputs ignored", {7'b0, chg_flag}, 8'h00);
    pulse(1, 8'hFF);
    wait_n(1);
    check("R6 input again", {7'b0, chg_flag}, 8'h01);
    resync_clear();

    // R8: external edge on bit 0 (pin_in bit0 currently 1)
    pulse(4, 8'h00);
    check("R8 cleared", {7'b0, ext_flag}, 8'h00);
    pin_in = 8'hF6;
    wait_n(4);
    check("R8 fall ignored on rising", {7'b0, ext_flag}, 8'h00);
    pin_in = 8'hF7;
    wait_n(2);
    check("R8 not yet", {7'b0, ext_flag}, 8'h00);
    wait_n(1);
    check("R8 rise sets", {7'b0, ext_flag}, 8'h01);
    wait_n(3);
    check("R8 sticky", {7'b0, ext_flag}, 8'h01);
    pulse(4, 8'h00);
    check("R8 clear", {7'b0, ext_flag}, 8'h00);
    pulse(2, 8'h00);
    check("R3 pu with falling cfg", pin_pu, 8'hFF);
    pin_in = 8'hF6;
    wait_n(3);
    check("R8 falling sets", {7'b0, ext_flag}, 8'h01);
    pulse(4, 8'h00);
    pin_in = 8'hF7;
    wait_n(4);
    check("R8 rise ignored on falling", {7'b0, ext_flag}, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule